// File: doc/BRIEF.md
# Counter-Flow Weight-Stationary FIR Array

This block computes a finite impulse response over a stream of signed samples with a linear chain of identical tap cells. Each cell holds one coefficient for the whole run. Samples enter at the head of the chain and move one cell per clock toward the tail. A zero partial sum enters at the tail each clock and moves one cell per clock back toward the head. Each cell adds the product of its coefficient and the passing sample to the passing partial sum. The finished result leaves at the head, on the same side where samples enter.

Samples and partial sums cross each other, so a partial sum meets a new sample every second cycle. For that reason the array works in slots. A slot indicator toggles every cycle. In single-stream mode only even slots carry samples, and the odd slots are empty bubbles. In interleave mode the odd slots carry a second, independent stream, and each result is tagged with the stream it belongs to. Inside each cell the multiply and the accumulate sit in separate register stages. Their work overlaps, and the latency from a sample to its result is the same for any number of taps.

Coefficients are shifted in serially while a load strobe is high. Loading suspends sample intake and wipes the sample history and every partial sum in flight.

Top module: `cf_systolic_fir`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and `slot_odd` is 0.
- R2: Outside loading, `slot_odd` inverts every clock. A cycle with `load_en` high makes the next cycle an even slot (`slot_odd` = 0).
- R3: On each clock with `load_en` high, `coef_in` enters tap 0 and every tap passes its coefficient to the next higher tap. After TAPS loads, the value loaded last sits at tap 0, which multiplies the newest sample. Coefficients hold while `load_en` is low.
- R4: During a load cycle no sample is accepted. `out_valid` is 0 in the cycle after any load cycle. The sample history of both slot parities restarts from all zeros.
- R5: In single-stream mode (`interleave` = 0), a sample offered in an odd slot is ignored. It produces no result and has no effect on later results.
- R6: A sample is accepted when `in_valid` is 1, `load_en` is 0, and the slot is even or interleave mode is set. Its result is sum over c of coef[c]·x[m−c], where x[m−c] is the value accepted c slots earlier of the same parity. A slot of that parity with no accepted sample counts as 0.
- R7: The result of a sample accepted in cycle n is presented with `out_valid` = 1 in cycle n+2, for any tap count. `out_valid` is 1 in no other cycle.
- R8: In interleave mode, even-slot samples form stream 0 and odd-slot samples form stream 1. Each stream has its own history, and `out_stream` gives the parity of the originating slot (0 even, 1 odd).
- R9: Samples and coefficients are two's-complement. Results are exact two's-complement values of ACC_W bits, including the all-minimum corner (−128·−128 summed over every tap).
- R10: In single-stream mode every valid result carries `out_stream` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Coefficient shift strobe; suspends processing |
| coef_in | input | COEF_W | Coefficient entering tap 0 while loading |
| interleave | input | 1 | 1: odd slots carry a second stream |
| in_valid | input | 1 | A sample is offered this cycle |
| in_sample | input | SAMPLE_W | Signed sample |
| slot_odd | output | 1 | Parity of the current slot |
| out_valid | output | 1 | `out_result` holds a result |
| out_stream | output | 1 | Stream tag of the result |
| out_result | output | ACC_W | Signed filter result |

## Verification
On every cycle, assertions check that the slot parity alternates, that load cycles silence the output and wipe the tail sample register, and that a valid result always traces back to an offered, non-load slot two cycles earlier. They also check that consecutive results carry opposite stream tags, that single-stream results are tagged 0, that coefficients stay still outside loading, and that no accumulator stage wraps. Only the bench scenarios can show the arithmetic itself. These cover the tap order after a serial load (found with an impulse), exact sums under random gaps, ignored odd-slot samples, the independence of the two interleaved streams, and the signed extremes. All are checked against a software convolution kept per slot parity.

// File: rtl/cf_fir_pkg.sv
package cf_fir_pkg;

    localparam int DEF_TAPS     = 4;
    localparam int DEF_SAMPLE_W = 8;
    localparam int DEF_COEF_W   = 8;
    localparam int DEF_ACC_W    = 20;

    // parity of a slot doubles as the stream tag
    typedef enum logic {
        SLOT_EVEN = 1'b0,
        SLOT_ODD  = 1'b1
    } slot_e;

endpackage

// File: rtl/cf_slot_ctrl.sv
module cf_slot_ctrl
    import cf_fir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic interleave,
    input  logic in_valid,
    output logic accept,
    output logic slot_odd,
    output logic out_valid,
    output logic out_stream
);

    typedef struct packed {
        slot_e phase;
        logic  mul_v;
        slot_e mul_tag;
        logic  acc_v;
        slot_e acc_tag;
    } slot_state_t;

    slot_state_t st_q, st_d;
    logic        accept_d;

    always_comb begin
        st_d     = st_q;
        accept_d = in_valid && !load_en &&
                   (interleave || (st_q.phase == SLOT_EVEN));
        if (load_en) begin
            st_d.phase = SLOT_EVEN;
        end else begin
            st_d.phase = (st_q.phase == SLOT_EVEN) ? SLOT_ODD : SLOT_EVEN;
        end
        // stage 1 follows the multiply register, stage 2 the accumulate register
        st_d.mul_v   = accept_d;
        st_d.mul_tag = st_q.phase;
        st_d.acc_v   = st_q.mul_v && !load_en;
        st_d.acc_tag = st_q.mul_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept     = accept_d;
    assign slot_odd   = st_q.phase;
    assign out_valid  = st_q.acc_v;
    assign out_stream = st_q.acc_tag;

    // R2
    slot_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (slot_odd != $past(slot_odd)));

    // R4
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !out_valid);

    // R7
    result_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid, 2) && !$past(load_en, 2) && !$past(load_en, 1)));

    // R8
    tag_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_stream != $past(out_stream)));

    // R10
    single_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(interleave, 2)) |-> (out_stream == SLOT_EVEN));

endmodule

// File: rtl/cf_tap_cell.sv
module cf_tap_cell #(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 8,
    parameter int ACC_W    = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_en,
    input  logic signed [COEF_W-1:0]   coef_prev,
    output logic signed [COEF_W-1:0]   coef_out,
    input  logic signed [SAMPLE_W-1:0] x_in,
    output logic signed [SAMPLE_W-1:0] x_out,
    input  logic signed [ACC_W-1:0]    y_in,
    output logic signed [ACC_W-1:0]    y_out
);

    localparam int PROD_W = SAMPLE_W + COEF_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    typedef struct packed {
        logic signed [COEF_W-1:0]   coef;
        logic signed [SAMPLE_W-1:0] x;
        logic signed [PROD_W-1:0]   prod;
        logic signed [ACC_W-1:0]    y;
    } cell_state_t;

    cell_state_t       st_q, st_d;
    logic [ACC_W:0]    wide_sum;
    logic [ACC_W-1:0]  prod_ext;

    always_comb begin
        st_d     = st_q;
        prod_ext = {{EXT_W{st_q.prod[PROD_W-1]}}, st_q.prod};
        wide_sum = {y_in[ACC_W-1], y_in} + {prod_ext[ACC_W-1], prod_ext};
        if (load_en) begin
            st_d.coef = coef_prev;
            st_d.x    = '0;
            st_d.prod = '0;
            st_d.y    = '0;
        end else begin
            st_d.x    = x_in;
            st_d.prod = PROD_W'(x_in) * PROD_W'(st_q.coef);
            st_d.y    = wide_sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign coef_out = st_q.coef;
    assign x_out    = st_q.x;
    assign y_out    = st_q.y;

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |-> (wide_sum[ACC_W] == wide_sum[ACC_W-1]));

endmodule

// File: rtl/cf_systolic_fir.sv
module cf_systolic_fir
    import cf_fir_pkg::*;
#(
    parameter int TAPS     = DEF_TAPS,
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int COEF_W   = DEF_COEF_W,
    parameter int ACC_W    = DEF_ACC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [COEF_W-1:0]   coef_in,
    input  logic                interleave,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                slot_odd,
    output logic                out_valid,
    output logic                out_stream,
    output logic [ACC_W-1:0]    out_result
);

    localparam int LAST = TAPS - 1;

    logic                       accept;
    logic signed [COEF_W-1:0]   coef_link [TAPS+1];
    logic signed [SAMPLE_W-1:0] x_link    [TAPS+1];
    logic signed [ACC_W-1:0]    y_link    [TAPS+1];

    cf_slot_ctrl u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .interleave (interleave),
        .in_valid   (in_valid),
        .accept     (accept),
        .slot_odd   (slot_odd),
        .out_valid  (out_valid),
        .out_stream (out_stream)
    );

    // head: gated sample and new coefficient; tail: zero partial sum
    assign coef_link[0] = coef_in;
    assign x_link[0]    = accept ? in_sample : '0;
    assign y_link[TAPS] = '0;

    for (genvar c = 0; c < TAPS; c++) begin : g_tap
        cf_tap_cell #(
            .SAMPLE_W (SAMPLE_W),
            .COEF_W   (COEF_W),
            .ACC_W    (ACC_W)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (load_en),
            .coef_prev (coef_link[c]),
            .coef_out  (coef_link[c+1]),
            .x_in      (x_link[c]),
            .x_out     (x_link[c+1]),
            .y_in      (y_link[c+1]),
            .y_out     (y_link[c])
        );
    end

    assign out_result = y_link[0];

    // R3
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(coef_link[TAPS]));

    // R4
    hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (x_link[TAPS] == '0) && (y_link[LAST] == '0));

endmodule

// File: tb/cf_systolic_fir_test.sv
`timescale 1ns/1ps
module cf_systolic_fir_test;

    localparam int K = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [7:0]  coef_in = '0;
    logic        interleave = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_sample = '0;
    logic        slot_odd;
    logic        out_valid;
    logic        out_stream;
    logic [19:0] out_result;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model
    int wm [K];
    int hist [2][K];
    bit ph = 0;
    bit exp_v [4];
    bit exp_s [4];
    int exp_d [4];
    int cyc = 0;

    always #2.5 clk = ~clk;

    cf_systolic_fir uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .coef_in(coef_in),
        .interleave(interleave), .in_valid(in_valid), .in_sample(in_sample),
        .slot_odd(slot_odd), .out_valid(out_valid), .out_stream(out_stream),
        .out_result(out_result)
    );

    function automatic int conv(input int par);
        int acc = 0;
        for (int c = 0; c < K; c++) acc += wm[c] * hist[par][c];
        return acc;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // called at a falling edge: check outputs, then drive one cycle of inputs
    task automatic step(input bit ld, input logic [7:0] w, input bit ilv,
                        input bit v, input logic [7:0] s, input string tag);
        int  i  = cyc % 4;
        int  n2 = (cyc + 2) % 4;
        bit  acc;
        check("R2 slot phase", int'(slot_odd), int'(ph));
        check("R7 valid timing", int'(out_valid), int'(exp_v[i]));
        if (exp_v[i] && out_valid) begin
            check(ilv ? "R8 stream tag" : "R10 stream tag", int'(out_stream), int'(exp_s[i]));
            check(tag, int'($signed(out_result)), exp_d[i]);
        end
        exp_v[i] = 0;
        load_en = ld; coef_in = w; interleave = ilv; in_valid = v; in_sample = s;
        if (ld) begin
            for (int c = K - 1; c > 0; c--) wm[c] = wm[c-1];
            wm[0] = int'($signed(w));
            for (int p = 0; p < 2; p++)
                for (int c = 0; c < K; c++) hist[p][c] = 0;
            exp_v[(cyc + 1) % 4] = 0;
            exp_v[n2] = 0;
            ph = 0;
        end else begin
            acc = v && (ilv || !ph);
            for (int c = K - 1; c > 0; c--) hist[ph][c] = hist[ph][c-1];
            hist[ph][0] = acc ? int'($signed(s)) : 0;
            exp_v[n2] = acc;
            exp_s[n2] = ph;
            exp_d[n2] = conv(int'(ph));
            ph = !ph;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic load4(input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c, input logic [7:0] d, input bit ilv);
        step(1, a, ilv, 0, 8'h00, "R3");
        step(1, b, ilv, 0, 8'h00, "R3");
        step(1, c, ilv, 0, 8'h00, "R3");
        step(1, d, ilv, 1, 8'h55, "R3");
        // R4: no result in the cycle after a load cycle
        check("R4 quiet after load", int'(out_valid), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 slot in reset", int'(slot_odd), 0);
        rst_n = 1'b1;

        // R3: impulse reveals tap order (last loaded value at tap 0)
        load4(8'd5, 8'hFD, 8'd7, 8'd2, 0);
        step(0, 0, 0, 1, 8'd1, "R3 impulse");
        for (int j = 0; j < 12; j++) step(0, 0, 0, 1, 8'd0, "R3 impulse");

        // R5 R6: single stream, random gaps, junk offered in odd slots
        load4(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 0);
        for (int j = 0; j < 80; j++)
            step(0, 0, 0, ($urandom % 5) != 0, 8'($urandom), "R5 R6 single stream");

        // R4: load in the middle of a busy stream
        for (int j = 0; j < 6; j++) step(0, 0, 0, 1, 8'($urandom), "R6");
        load4(8'd1, 8'd1, 8'd1, 8'd1, 0);
        for (int j = 0; j < 12; j++) step(0, 0, 0, 1, 8'($urandom), "R4 history restart");

        // R9: signed extremes
        load4(8'h80, 8'h80, 8'h80, 8'h80, 0);
        for (int j = 0; j < 12; j++) step(0, 0, 0, 1, 8'h80, "R9 min corner");
        for (int j = 0; j < 12; j++) step(0, 0, 0, 1, (j % 4 < 2) ? 8'h7F : 8'h80, "R9 mixed");

        // R8: two interleaved streams
        load4(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1);
        for (int j = 0; j < 90; j++)
            step(0, 0, 1, ($urandom % 6) != 0, 8'($urandom), "R8 interleave");
        // stream B silent: stream A must be unaffected
        for (int j = 0; j < 20; j++)
            step(0, 0, 1, !ph, 8'($urandom), "R8 one stream idle");

        // drain
        for (int j = 0; j < 6; j++) step(0, 0, 1, 0, 8'h00, "R6 drain");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule